// File: doc/BRIEF.md
# Nibble-Serial Register Command Decoder

The block interprets a stream of one-byte commands arriving from a host over a byte channel. Each byte holds a 4-bit opcode in its upper half and a 4-bit operand in its lower half. Because a byte has room for only one nibble of payload, the decoder builds an 8-bit register address and an 8-bit write value from separate low and high nibble commands. It then writes to, or reads back from, a 256-entry register file of 8-bit entries.

A read command returns the selected register through a one-cycle valid pulse. Operand bits of the read command can then step the address up or down, which lets the host stream consecutive locations without reloading the address. The remaining opcodes are requests for a separate sample-memory controller. The decoder turns them into single-cycle strobes with a bank bit. One of them stalls command acceptance until that controller reports completion.

Top module: `nib_cmd_decoder`

## Requirements
- R1: A byte is accepted in a cycle where `cmd_valid_i` and `cmd_ready_o` are both high. Bits [7:4] are the opcode and bits [3:0] are the operand. A byte presented with `cmd_valid_i` low has no effect.
- R2: Opcode 0x0 loads the operand into address bits [3:0]. Opcode 0x1 loads it into address bits [7:4]. The other address nibble is kept.
- R3: Opcode 0x2 stores the operand as the pending low data nibble. Opcode 0x3 writes {operand, pending nibble} into the register at the current address, and the address does not change.
- R4: Opcode 0x4 raises `rd_valid_o` for exactly the cycle after acceptance. In that cycle `rd_data_o` carries the register at the address held when the command was accepted. `rd_data_o` holds its last value at other times.
- R5: For opcode 0x4, operand bit 0 = 1 moves the address after the read: it decrements when operand bit 1 = 1 and increments when operand bit 1 = 0. With bit 0 = 0 the address is kept.
- R6: Address stepping wraps modulo 256, so 0xFF+1 gives 0x00 and 0x00-1 gives 0xFF.
- R7: After opcode 0x5 is accepted, `cmd_ready_o` is low from the next cycle. It rises again in the cycle after one in which `mem_done_i` is sampled high. `mem_done_i` has no effect while no wait is pending.
- R8: Opcodes 0x6/0x7, 0x8/0x9 and 0xA/0xB pulse `mem_blk_start_o`, `mem_blk_head_o` and `mem_blk_full_o` respectively for one cycle, in the cycle after acceptance. `mem_bank_o` equals opcode bit 0 during that pulse and is low otherwise. At most one strobe is high at a time.
- R9: Opcodes 0xC to 0xF change nothing: not the address, the pending nibble, the registers or any output.
- R10: While `rst_ni` is low, the address, the pending nibble and all registers are cleared. All outputs are low, except `cmd_ready_o`, which is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command byte present |
| cmd_byte_i | input | 8 | Command byte: opcode [7:4], operand [3:0] |
| cmd_ready_o | output | 1 | Decoder can accept a byte |
| rd_valid_o | output | 1 | Read data pulse |
| rd_data_o | output | 8 | Read data |
| mem_done_i | input | 1 | Sample-memory transfer complete |
| mem_blk_start_o | output | 1 | Block transfer start strobe |
| mem_blk_head_o | output | 1 | Read first buffered bytes strobe |
| mem_blk_full_o | output | 1 | Read full buffered block strobe |
| mem_bank_o | output | 1 | Bank select, valid with a strobe |

## Verification
A wrong address or pending nibble stays hidden until the next read. The bench therefore follows each write pattern with reads, including reads that step across 0xFF and 0x00, so that a bad address step or a bad nibble merge shows up in `rd_data_o` one cycle after the read command. A stuck or misplaced wait state shows up in `cmd_ready_o` within one cycle of the wait opcode or of `mem_done_i`. A mis-decoded opcode shows up as a wrong strobe or bank bit in the cycle after it is accepted. A long random stream is compared against the model on every clock.

// File: rtl/nib_cmd_pkg.sv
package nib_cmd_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef enum logic [NIB_W-1:0] {
    OP_ADDR_LO = 4'h0,
    OP_ADDR_HI = 4'h1,
    OP_DATA_LO = 4'h2,
    OP_DATA_WR = 4'h3,
    OP_READ    = 4'h4,
    OP_WAIT    = 4'h5
  } opcode_e;

  typedef struct packed {
    logic addr_lo;
    logic addr_hi;
    logic data_lo;
    logic wr;
    logic rd;
    logic wait_req;
    logic blk_start;
    logic blk_head;
    logic blk_full;
    logic bank;
  } cmd_dec_t;
endpackage

// File: rtl/nib_cmd_parse.sv
module nib_cmd_parse
  import nib_cmd_pkg::*;
(
  input  logic              accept_i,
  input  logic [BYTE_W-1:0] byte_i,
  output cmd_dec_t          dec_o,
  output logic [NIB_W-1:0]  operand_o
);
  logic [NIB_W-1:0] op;
  assign op        = byte_i[BYTE_W-1:NIB_W];
  assign operand_o = byte_i[NIB_W-1:0];

  always_comb begin
    dec_o = '0;
    if (accept_i) begin
      unique case (op)
        OP_ADDR_LO: dec_o.addr_lo  = 1'b1;
        OP_ADDR_HI: dec_o.addr_hi  = 1'b1;
        OP_DATA_LO: dec_o.data_lo  = 1'b1;
        OP_DATA_WR: dec_o.wr       = 1'b1;
        OP_READ:    dec_o.rd       = 1'b1;
        OP_WAIT:    dec_o.wait_req = 1'b1;
        4'h6, 4'h7: dec_o.blk_start = 1'b1;
        4'h8, 4'h9: dec_o.blk_head  = 1'b1;
        4'hA, 4'hB: dec_o.blk_full  = 1'b1;
        default: ;
      endcase
      dec_o.bank = op[0] & (dec_o.blk_start | dec_o.blk_head | dec_o.blk_full);
    end
  end
endmodule

// File: rtl/nib_addr_ctl.sv
module nib_addr_ctl
  import nib_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_dec_t          dec_i,
  input  logic [NIB_W-1:0]  operand_i,
  output logic [BYTE_W-1:0] addr_o,
  output logic [NIB_W-1:0]  data_lo_o
);
  logic [BYTE_W-1:0] addr_q;
  logic [NIB_W-1:0]  lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      lo_q   <= '0;
    end else begin
      if (dec_i.addr_lo) addr_q[NIB_W-1:0]      <= operand_i;
      if (dec_i.addr_hi) addr_q[BYTE_W-1:NIB_W] <= operand_i;
      if (dec_i.data_lo) lo_q <= operand_i;
      // step happens on the same edge the read value is captured from the old address
      if (dec_i.rd && operand_i[0])
        addr_q <= operand_i[1] ? addr_q - BYTE_W'(1) : addr_q + BYTE_W'(1);
    end
  end

  assign addr_o    = addr_q;
  assign data_lo_o = lo_q;
endmodule

// File: rtl/nib_reg_file.sv
module nib_reg_file #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '0;
      else if (we_i && addr_i == ADDR_W'(g))   mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/nib_cmd_decoder.sv
module nib_cmd_decoder
  import nib_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [BYTE_W-1:0] cmd_byte_i,
  output logic              cmd_ready_o,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              mem_done_i,
  output logic              mem_blk_start_o,
  output logic              mem_blk_head_o,
  output logic              mem_blk_full_o,
  output logic              mem_bank_o
);
  cmd_dec_t          dec;
  logic [NIB_W-1:0]  operand;
  logic [BYTE_W-1:0] addr_w;
  logic [NIB_W-1:0]  data_lo;
  logic [BYTE_W-1:0] rdata;
  logic              waiting_q;
  logic              accept;

  assign cmd_ready_o = ~waiting_q;
  assign accept      = cmd_valid_i & cmd_ready_o;

  nib_cmd_parse u_parse (
    .accept_i  (accept),
    .byte_i    (cmd_byte_i),
    .dec_o     (dec),
    .operand_o (operand)
  );

  nib_addr_ctl u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dec_i     (dec),
    .operand_i (operand),
    .addr_o    (addr_w),
    .data_lo_o (data_lo)
  );

  nib_reg_file #(.ADDR_W(BYTE_W), .DATA_W(BYTE_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (dec.wr),
    .addr_i  (addr_w),
    .wdata_i ({operand, data_lo}),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waiting_q       <= 1'b0;
      rd_valid_o      <= 1'b0;
      rd_data_o       <= '0;
      mem_blk_start_o <= 1'b0;
      mem_blk_head_o  <= 1'b0;
      mem_blk_full_o  <= 1'b0;
      mem_bank_o      <= 1'b0;
    end else begin
      if (dec.wait_req)              waiting_q <= 1'b1;
      else if (waiting_q && mem_done_i) waiting_q <= 1'b0;
      rd_valid_o      <= dec.rd;
      if (dec.rd) rd_data_o <= rdata;
      mem_blk_start_o <= dec.blk_start;
      mem_blk_head_o  <= dec.blk_head;
      mem_blk_full_o  <= dec.blk_full;
      mem_bank_o      <= dec.bank;
    end
  end
endmodule

// File: rtl/nib_cmd_decoder_chk.sv
module nib_cmd_decoder_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [7:0]        cmd_byte_i,
  input logic              cmd_ready_o,
  input logic              rd_valid_o,
  input logic              mem_done_i,
  input logic              mem_blk_start_o,
  input logic              mem_blk_head_o,
  input logic              mem_blk_full_o,
  input logic              mem_bank_o,
  input logic [ADDR_W-1:0] addr_q
);
  logic acc;
  assign acc = cmd_valid_i & cmd_ready_o;

  p_rd_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(acc && cmd_byte_i[7:4] == 4'h4));

  p_step_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_byte_i[7:4] == 4'h4 && cmd_byte_i[1:0] == 2'b01)
      |=> addr_q == $past(addr_q) + ADDR_W'(1));

  p_step_down_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_byte_i[7:4] == 4'h4 && cmd_byte_i[1:0] == 2'b11)
      |=> addr_q == $past(addr_q) - ADDR_W'(1));

  p_wait_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_byte_i[7:4] == 4'h5) |=> !cmd_ready_o);

  p_wait_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_ready_o && !mem_done_i) |=> !cmd_ready_o);

  p_strobe_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_blk_start_o, mem_blk_head_o, mem_blk_full_o}));

  p_bank_qual_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_bank_o |-> (mem_blk_start_o | mem_blk_head_o | mem_blk_full_o));

  p_start_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_blk_start_o |-> $past(acc && cmd_byte_i[7:5] == 3'b011));

  p_unused_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_byte_i[7:6] == 2'b11) |=> $stable(addr_q));
endmodule

bind nib_cmd_decoder nib_cmd_decoder_chk #(.ADDR_W(8)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cmd_valid_i     (cmd_valid_i),
  .cmd_byte_i      (cmd_byte_i),
  .cmd_ready_o     (cmd_ready_o),
  .rd_valid_o      (rd_valid_o),
  .mem_done_i      (mem_done_i),
  .mem_blk_start_o (mem_blk_start_o),
  .mem_blk_head_o  (mem_blk_head_o),
  .mem_blk_full_o  (mem_blk_full_o),
  .mem_bank_o      (mem_bank_o),
  .addr_q          (addr_w)
);

// File: tb/nib_cmd_decoder_tb_top.sv
module nib_cmd_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       valid;
  logic [7:0] cmd;
  logic       done;
  logic       ready, rdv, st, hd, fl, bk;
  logic [7:0] rdd;

  always #4 clk = ~clk;

  nib_cmd_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_byte_i(cmd),
    .cmd_ready_o(ready), .rd_valid_o(rdv), .rd_data_o(rdd), .mem_done_i(done),
    .mem_blk_start_o(st), .mem_blk_head_o(hd), .mem_blk_full_o(fl), .mem_bank_o(bk)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit rand_done = 0;

  // behavioural model
  int m_regs[256];
  int m_addr, m_lat, e_rdd;
  bit m_wait, e_rdv, e_st, e_hd, e_fl, e_bk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_regs[i]) m_regs[i] = 0;
      m_addr = 0; m_lat = 0; m_wait = 0; e_rdd = 0;
      e_rdv = 0; e_st = 0; e_hd = 0; e_fl = 0; e_bk = 0;
    end else begin
      int op, od;
      op = cmd[7:4]; od = cmd[3:0];
      e_rdv = 0; e_st = 0; e_hd = 0; e_fl = 0; e_bk = 0;
      if (m_wait) begin
        if (done) m_wait = 0;
      end else if (valid) begin
        case (op)
          0: m_addr = (m_addr & 'hF0) | od;
          1: m_addr = (m_addr & 'h0F) | (od << 4);
          2: m_lat = od;
          3: m_regs[m_addr] = (od << 4) | m_lat;
          4: begin
            e_rdv = 1; e_rdd = m_regs[m_addr];
            if (od & 1) m_addr = (od & 2) ? (m_addr + 255) % 256 : (m_addr + 1) % 256;
          end
          5: m_wait = 1;
          6, 7:   begin e_st = 1; e_bk = op & 1; end
          8, 9:   begin e_hd = 1; e_bk = op & 1; end
          10, 11: begin e_fl = 1; e_bk = op & 1; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk(ready, !m_wait, "R7 cmd_ready_o");
      chk(rdv, e_rdv, "R4 rd_valid_o");
      chk(rdd, e_rdd, "R4/R5 rd_data_o");
      chk(st, e_st, "R8 mem_blk_start_o");
      chk(hd, e_hd, "R8 mem_blk_head_o");
      chk(fl, e_fl, "R8 mem_blk_full_o");
      chk(bk, e_bk, "R8 mem_bank_o");
    end
  end

  always @(negedge clk) if (rand_done) done <= ($urandom_range(0, 3) == 0);

  // call at a negedge
  task automatic send(input logic [7:0] b);
    while (!ready) @(negedge clk);
    valid = 1'b1; cmd = b;
    @(negedge clk);
    valid = 1'b0; cmd = $urandom_range(0, 255);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; valid = 1'b0; cmd = 8'h00; done = 1'b0;
    repeat (3) @(negedge clk);
    chk(ready, 1, "R10 ready in reset");
    chk(rdv | st | hd | fl | bk, 0, "R10 outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R10: register 0 reads zero
    send(8'h40); @(negedge clk);
    // R2 R3: write 0xA5 to 0xFF, then R5/R6 wrap up and down
    send(8'h0F); send(8'h1F); send(8'h25); send(8'h3A);
    send(8'h41);                 // read 0xFF, step to 0x00
    send(8'h40);                 // read 0x00
    send(8'h43);                 // read 0x00, step to 0xFF
    send(8'h40);                 // R6: back at 0xFF
    // R1: byte without valid is ignored
    cmd = 8'h03; @(negedge clk); @(negedge clk);
    send(8'h40);
    // R9: unused opcodes
    send(8'hC1); send(8'hD7); send(8'hE3); send(8'hFF);
    send(8'h40);
    // R8: memory strobes with bank
    send(8'h60); send(8'h70); send(8'h80); send(8'h90); send(8'hA0); send(8'hB0);
    // R7: wait holds until done
    send(8'h50);
    repeat (5) @(negedge clk);
    done = 1'b1; @(negedge clk); done = 1'b0;
    repeat (2) @(negedge clk);
    // R7: done ignored while idle
    done = 1'b1; @(negedge clk); done = 1'b0; @(negedge clk);
    // random stream
    rand_done = 1;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 3) == 0) @(negedge clk);
      send($urandom_range(0, 255));
    end
    rand_done = 0;
    done = 1'b1;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule